// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable hardware event counter. Every clock cycle it is handed a small count of how many times a chosen event happened in that cycle, together with the privilege level the thread is running at. A configuration word decides how that per-cycle count turns into counter increments. The counter either accumulates the raw count, or adds one when a threshold test passes. That test may be inverted, restricted to rising edges, and filtered by privilege level.

Software writes the configuration word, can load the 48-bit counter at any time, and reads its value directly. A carry out of the top bit sets a sticky overflow flag. The flag raises an interrupt when interrupt enable is set. The event select and unit mask fields are only held in the register and presented on outputs, so that neighbouring logic can decode them into the actual event source.

Configuration word layout (cfgWdata): bits 7:0 event select, bits 15:8 unit mask, bits 23:16 threshold, bit 24 invert, bit 25 edge mode, bit 26 user enable, bit 27 kernel enable, bit 28 interrupt enable, bit 29 global enable.

Top module: `qual_event_counter`

## Requirements
- R1: After reset the counter reads 0, the overflow flag and irq are 0, and the configuration is all zero (counting disabled, select outputs 0).
- R2: With threshold 0, each enabled cycle whose privilege passes adds the full 4-bit evtCount to the counter. Edge mode and invert have no effect in this case.
- R3: With a nonzero threshold and invert clear, the counter adds exactly one in a cycle where evtCount, zero-extended to 8 bits, is greater than or equal to the unsigned threshold, and nothing otherwise.
- R4: With a nonzero threshold and invert set (bit 24), the counter adds one in a cycle where evtCount is less than the threshold.
- R5: With edge mode (bit 25) and a nonzero threshold, one is added only in a cycle where the qualified condition (threshold test and privilege pass) is true and was false in the previous cycle. The remembered previous condition reads false after any disabled cycle or any configuration write cycle.
- R6: privLevel 0 is counted only if kernel enable (bit 27) is set, and levels 1 to 3 only if user enable (bit 26) is set. When both bits are clear, all levels are counted.
- R7: When global enable (bit 29) is clear, and in any cycle in which cfgWe is high, the counter does not increment.
- R8: A counter load (cntWe) takes cntWdata in the next cycle, replacing any increment of the same cycle.
- R9: An increment that carries out of bit 47 wraps the counter and sets the sticky overflow flag. The flag stays set until ovfClr, and a new overflow wins over a clear in the same cycle. irq equals the overflow flag ANDed with interrupt enable (bit 28).
- R10: The evtSel and unitMask outputs show bits 7:0 and 15:8 of the last written configuration from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtCount | input | 4 | Occurrences of the selected event this cycle |
| privLevel | input | 2 | Current privilege level, 0 is most privileged |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 30 | Configuration word |
| cntWe | input | 1 | Counter load strobe |
| cntWdata | input | 48 | Counter load value |
| ovfClr | input | 1 | Clears the overflow flag |
| cntValue | output | 48 | Current counter value |
| ovfFlag | output | 1 | Sticky overflow status |
| irq | output | 1 | Overflow interrupt |
| evtSel | output | 8 | Stored event select |
| unitMask | output | 8 | Stored unit mask |

## Verification
A wrong remembered edge state shows up at cntValue one cycle after the next qualifying cycle: either a missing increment or an extra one. A mis-decoded privilege or threshold field shows up as a wrong count on the very first cycle that uses it. Overflow mistakes appear in ovfFlag and irq in the cycle right after the wrapping increment. Because the counter is visible on every cycle, every error in qualification shows up within one clock of its cause.

// File: rtl/qec_pkg.sv
package qec_pkg;
  typedef struct packed {
    logic       enable;
    logic       irqEn;
    logic       kernEn;
    logic       userEn;
    logic       edgeMode;
    logic       invert;
    logic [7:0] thresh;
    logic [7:0] unitMask;
    logic [7:0] evtSel;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef struct packed {
    logic       load;
    logic       addEn;
    logic [7:0] addAmt;
    logic       irqEn;
  } strobe_t;
endpackage

// File: rtl/qec_ctrl.sv
module qec_ctrl
  import qec_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evtCount,
  input  logic [1:0]       privLevel,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             cntWe,
  output cfg_t             cfgQ,
  output strobe_t          strb
);
  logic prevCond;
  logic effUser, effKern, privOk;
  logic thrZero, geThr, cond, qCond, active;

  always_ff @(posedge clk) begin
    if (!rst_n) cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfg_t'(cfgWdata);
  end

  always_comb begin
    effUser = cfgQ.userEn | ~(cfgQ.userEn | cfgQ.kernEn);
    effKern = cfgQ.kernEn | ~(cfgQ.userEn | cfgQ.kernEn);
    privOk  = (privLevel == 2'd0) ? effKern : effUser;
    thrZero = (cfgQ.thresh == 8'd0);
    geThr   = (8'(evtCount) >= cfgQ.thresh);
    cond    = cfgQ.invert ? ~geThr : geThr;
    qCond   = cond & privOk;
    active  = cfgQ.enable & ~cfgWe;

    strb.load  = cntWe;
    strb.irqEn = cfgQ.irqEn;
    if (thrZero) begin
      strb.addEn  = active & privOk;
      strb.addAmt = 8'(evtCount);
    end else begin
      strb.addEn  = active & qCond & (~cfgQ.edgeMode | ~prevCond);
      strb.addAmt = 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prevCond <= 1'b0;
    else        prevCond <= active & qCond;
  end

  p_cfg_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWe |-> !strb.addEn);
  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgQ.enable |-> !strb.addEn);
  p_edge_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgQ.edgeMode && cfgQ.thresh != 8'd0 && strb.addEn) |=> !strb.addEn);
  p_priv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.addEn && privLevel == 2'd0 && cfgQ.userEn) |-> cfgQ.kernEn);
endmodule

// File: rtl/qec_datapath.sv
module qec_datapath
  import qec_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] cntWdata,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] cntValue,
  output logic             ovfFlag,
  output logic             irq
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cntValue} + (CNT_W+1)'(strb.addAmt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntValue <= '0;
      ovfFlag  <= 1'b0;
    end else begin
      if (strb.load)       cntValue <= cntWdata;
      else if (strb.addEn) cntValue <= sum[CNT_W-1:0];
      if (!strb.load && strb.addEn && sum[CNT_W]) ovfFlag <= 1'b1;
      else if (ovfClr)                            ovfFlag <= 1'b0;
    end
  end

  assign irq = ovfFlag & strb.irqEn;

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> cntValue == $past(cntWdata));
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfFlag && !ovfClr) |=> ovfFlag);
  p_irq_needs_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovfFlag);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.load && !strb.addEn) |=> $stable(cntValue));
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
  import qec_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evtCount,
  input  logic [1:0]       privLevel,
  input  logic             cfgWe,
  input  logic [29:0]      cfgWdata,
  input  logic             cntWe,
  input  logic [CNT_W-1:0] cntWdata,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] cntValue,
  output logic             ovfFlag,
  output logic             irq,
  output logic [7:0]       evtSel,
  output logic [7:0]       unitMask
);
  cfg_t    cfgQ;
  strobe_t strb;

  qec_ctrl #(.EVT_W(EVT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evtCount(evtCount), .privLevel(privLevel),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cntWe(cntWe),
    .cfgQ(cfgQ), .strb(strb)
  );

  qec_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cntWdata(cntWdata),
    .ovfClr(ovfClr), .cntValue(cntValue), .ovfFlag(ovfFlag), .irq(irq)
  );

  assign evtSel   = cfgQ.evtSel;
  assign unitMask = cfgQ.unitMask;
endmodule

// File: tb/qual_event_counter_bench.sv
module qual_event_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  evtCount = 0;
  logic [1:0]  privLevel = 0;
  logic        cfgWe = 0;
  logic [29:0] cfgWdata = 0;
  logic        cntWe = 0;
  logic [47:0] cntWdata = 0;
  logic        ovfClr = 0;
  logic [47:0] cntValue;
  logic        ovfFlag, irq;
  logic [7:0]  evtSel, unitMask;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [47:0] cnt;
    logic        ovf;
    logic        irq;
    logic [7:0]  sel;
    logic [7:0]  um;
    string       tag;
  } exp_t;
  exp_t q[$];

  // model state
  logic [29:0] mCfg = 0;
  logic [47:0] mCnt = 0;
  logic        mOvf = 0;
  logic        mPrev = 0;

  qual_event_counter u_qual_event_counter (
    .clk(clk), .rst_n(rst_n), .evtCount(evtCount), .privLevel(privLevel),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cntWe(cntWe), .cntWdata(cntWdata),
    .ovfClr(ovfClr), .cntValue(cntValue), .ovfFlag(ovfFlag), .irq(irq),
    .evtSel(evtSel), .unitMask(unitMask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [29:0] mk(input logic [7:0] sel, input logic [7:0] um,
      input logic [7:0] thr, input bit inv, input bit edg, input bit usr,
      input bit krn, input bit ie, input bit en);
    return {en, ie, krn, usr, edg, inv, thr, um, sel};
  endfunction

  task automatic step(input logic [3:0] c, input logic [1:0] p, input bit cw,
      input logic [29:0] cv, input bit lw, input logic [47:0] lv, input bit clr,
      input string tag);
    exp_t e;
    logic [7:0] thr;
    bit usr, krn, pok, ge, cnd, qc, act, add;
    logic [48:0] s;
    logic [7:0] amt;
    evtCount = c; privLevel = p; cfgWe = cw; cfgWdata = cv;
    cntWe = lw; cntWdata = lv; ovfClr = clr;
    thr = mCfg[23:16];
    usr = mCfg[26]; krn = mCfg[27];
    if (!usr && !krn) begin usr = 1; krn = 1; end
    pok = (p == 0) ? krn : usr;
    ge  = ({4'd0, c} >= thr);
    cnd = mCfg[24] ? !ge : ge;
    qc  = cnd && pok;
    act = mCfg[29] && !cw;
    if (thr == 0) begin add = act && pok; amt = {4'd0, c}; end
    else begin add = act && qc && (!mCfg[25] || !mPrev); amt = 8'd1; end
    s = {1'b0, mCnt} + {41'd0, amt};
    if (!lw && add && s[48]) mOvf = 1;
    else if (clr) mOvf = 0;
    if (lw) mCnt = lv;
    else if (add) mCnt = s[47:0];
    mPrev = act && qc;
    if (cw) mCfg = cv;
    e.cnt = mCnt; e.ovf = mOvf; e.irq = mOvf && mCfg[28];
    e.sel = mCfg[7:0]; e.um = mCfg[15:8]; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(input logic [3:0] c, input logic [1:0] p, input string tag);
    step(c, p, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic cfg(input logic [29:0] v, input string tag);
    step(0, 0, 1, v, 0, 0, 0, tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (cntValue !== e.cnt || ovfFlag !== e.ovf || irq !== e.irq ||
          evtSel !== e.sel || unitMask !== e.um) begin
        bad++;
        $display("FAIL %s: got cnt=%0h ovf=%0b irq=%0b sel=%0h um=%0h exp cnt=%0h ovf=%0b irq=%0b sel=%0h um=%0h",
          e.tag, cntValue, ovfFlag, irq, evtSel, unitMask, e.cnt, e.ovf, e.irq, e.sel, e.um);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    total++;
    if (cntValue !== 0 || ovfFlag !== 0 || irq !== 0 || evtSel !== 0 || unitMask !== 0) begin
      bad++;
      $display("FAIL R1: got cnt=%0h ovf=%0b irq=%0b exp all zero", cntValue, ovfFlag, irq);
    end
    // R7 disabled: nothing counts
    run(5, 0, "R7"); run(9, 2, "R7");
    // R2 raw accumulate, R10 select outputs, R6 default both levels
    cfg(mk(8'h3C, 8'hA5, 0, 0, 0, 0, 0, 0, 1), "R10");
    run(3, 0, "R2"); run(7, 2, "R2"); run(15, 3, "R6"); run(0, 1, "R2");
    // R2 edge/invert ignored at threshold zero
    cfg(mk(8'h11, 8'h22, 0, 1, 1, 0, 0, 0, 1), "R7");
    run(4, 0, "R2"); run(4, 0, "R2");
    // R3 threshold 4
    cfg(mk(8'h01, 8'h02, 8'd4, 0, 0, 0, 0, 0, 1), "R7");
    run(3, 0, "R3"); run(4, 0, "R3"); run(9, 1, "R3"); run(15, 2, "R3");
    cfg(mk(8'h01, 8'h02, 8'd20, 0, 0, 0, 0, 0, 1), "R7");
    run(15, 0, "R3");
    // R4 invert
    cfg(mk(8'h01, 8'h02, 8'd4, 1, 0, 0, 0, 0, 1), "R7");
    run(3, 0, "R4"); run(4, 0, "R4"); run(0, 3, "R4");
    // R5 edge
    cfg(mk(8'h05, 8'h06, 8'd2, 0, 1, 0, 0, 0, 1), "R7");
    run(5, 0, "R5"); run(5, 0, "R5"); run(5, 0, "R5"); run(0, 0, "R5"); run(6, 0, "R5");
    cfg(mk(8'h05, 8'h06, 8'd2, 0, 1, 0, 0, 0, 0), "R7");
    run(6, 0, "R7");
    cfg(mk(8'h05, 8'h06, 8'd2, 0, 1, 0, 0, 0, 1), "R5");
    run(6, 0, "R5"); run(6, 0, "R5");
    // R6 privilege filtering
    cfg(mk(8'h07, 8'h08, 0, 0, 0, 0, 1, 0, 1), "R6");
    run(2, 0, "R6"); run(2, 3, "R6"); run(2, 1, "R6");
    cfg(mk(8'h07, 8'h08, 0, 0, 0, 1, 0, 0, 1), "R6");
    run(2, 0, "R6"); run(2, 2, "R6");
    // R8 load wins over increment
    step(9, 1, 0, 0, 1, 48'h1234_5678_9ABC, 0, "R8");
    run(1, 3, "R8");
    // R9 overflow
    cfg(mk(8'h09, 8'h0A, 0, 0, 0, 0, 0, 1, 1), "R9");
    step(0, 0, 0, 0, 1, 48'hFFFF_FFFF_FFFE, 0, "R8");
    run(5, 0, "R9"); run(1, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 1, 48'hFFFF_FFFF_FFFF, 0, "R8");
    step(1, 0, 0, 0, 0, 0, 1, "R9");
    cfg(mk(8'h09, 8'h0A, 0, 0, 0, 0, 0, 0, 1), "R9");
    step(0, 0, 0, 0, 0, 0, 1, "R9");
    run(0, 0, "R9");
    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule